// File: doc/BRIEF.md
# Linear CCD Clock Sequencer

This block produces the readout timing for a linear image sensor from a 20 MHz reference clock. It generates a pair of complementary transfer phases at 2.5 MHz and a one-clock sample strobe at the 5 MHz pixel rate. It also keeps a pixel index that walks through one readout frame after each shift-gate pulse. Sensor analog behaviour is not modelled.

A frame has 5076 pixel slots. The first 64 are leading dummies, the next 5000 carry image data, and the last 12 are trailing dummies. Each slot lasts four reference clocks. A falling edge on the shift-gate input ends light integration and starts a frame, and the transfer phases are realigned to it. When the last slot has gone out, the sequencer goes idle. While idle, the phases keep toggling, the region flags stay low and the index holds at its last value. The region flags and the frame markers let downstream capture logic pick out the image pixels without counting for itself.

Top module: `ccd_seq`

## Requirements
- R1: `ph1` and `ph2` are complementary. Each holds its level for four clocks and then toggles, giving an eight-clock period. In the first clock of every frame, `ph1` is high.
- R2: `rs` is high for exactly the first clock of each four-clock pixel slot while a frame runs. It is low while idle.
- R3: A frame starts at the first rising clock edge where `sg` is sampled low after having been sampled high. After that edge, `pix_idx` is 0 and `frame_start` is high for one clock. A rising edge of `sg`, or `sg` held high, has no other effect.
- R4: During a frame, `pix_idx` rises by one every four clocks, from 0 up to 5075. It then holds at 5075 until the next frame starts. After reset it is 0.
- R5: `lead_dmy` is high during a frame exactly while `pix_idx` is between 0 and 63.
- R6: `act` is high during a frame exactly while `pix_idx` is between 64 and 5063.
- R7: `trail_dmy` is high during a frame exactly while `pix_idx` is between 5064 and 5075. After the frame, all three region flags are low.
- R8: `frame_end` is high for the single clock that is the last clock of pixel 5075.
- R9: A falling edge of `sg` in the middle of a frame abandons that frame and starts a new one from pixel 0, as described in R3.
- R10: While `rst_n` is low, `ph1` is 1. All other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg | input | 1 | Shift-gate pulse; a falling edge starts readout |
| ph1 | output | 1 | Transfer phase 1 |
| ph2 | output | 1 | Transfer phase 2, the complement of `ph1` |
| rs | output | 1 | Per-pixel sample/reset strobe |
| pix_idx | output | 13 | Current pixel index within the frame |
| lead_dmy | output | 1 | Leading dummy region |
| act | output | 1 | Image pixel region |
| trail_dmy | output | 1 | Trailing dummy region |
| frame_start | output | 1 | First clock of a frame |
| frame_end | output | 1 | Last clock of the last pixel |

## Verification
The properties assume that `sg` is synchronous to `clk` and changes between edges. They also allow a restart to land on any clock, so that every property that spans a clock tolerates `frame_start` in the following cycle. The stimulus drives `sg` only on falling clock edges. It includes an idle gap before the first pulse, complete frames, a restart about a hundred pixels into a frame, and a long high level on `sg` that must leave the frame undisturbed.

// File: rtl/ccd_seq.sv
module ccd_seq #(
  parameter int CLK_PER_PIX = 4,
  parameter int LEAD        = 64,
  parameter int ACTIVE      = 5000,
  parameter int TRAIL       = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     sg,
  output logic                                     ph1,
  output logic                                     ph2,
  output logic                                     rs,
  output logic [$clog2(LEAD+ACTIVE+TRAIL)-1:0]     pix_idx,
  output logic                                     lead_dmy,
  output logic                                     act,
  output logic                                     trail_dmy,
  output logic                                     frame_start,
  output logic                                     frame_end
);
  localparam int TOTAL = LEAD + ACTIVE + TRAIL;
  localparam int IW    = $clog2(TOTAL);
  localparam int SW    = (CLK_PER_PIX > 1) ? $clog2(CLK_PER_PIX) : 1;
  localparam logic [IW-1:0] LAST_IDX  = IW'(TOTAL - 1);
  localparam logic [IW-1:0] ACT_FIRST = IW'(LEAD);
  localparam logic [IW-1:0] TR_FIRST  = IW'(LEAD + ACTIVE);
  localparam logic [SW-1:0] SUB_LAST  = SW'(CLK_PER_PIX - 1);

  logic          sg_q, run, ph;
  logic [SW-1:0] sub;
  logic [IW-1:0] idx;

  wire fall     = sg_q & ~sg;
  wire pix_last = (sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sg_q <= 1'b0;
      run  <= 1'b0;
      ph   <= 1'b0;
      sub  <= '0;
      idx  <= '0;
    end else begin
      sg_q <= sg;
      if (fall) begin
        run <= 1'b1;
        ph  <= 1'b0;
        sub <= '0;
        idx <= '0;
      end else begin
        sub <= pix_last ? '0 : sub + 1'b1;
        if (pix_last) ph <= ~ph;
        if (run && pix_last) begin
          if (idx == LAST_IDX) run <= 1'b0;
          else                 idx <= idx + 1'b1;
        end
      end
    end
  end

  assign ph1         = ~ph;
  assign ph2         = ph;
  assign pix_idx     = idx;
  assign rs          = run & (sub == '0);
  assign frame_start = run & (idx == '0) & (sub == '0);
  assign frame_end   = run & (idx == LAST_IDX) & pix_last;
  assign lead_dmy    = run & (idx < ACT_FIRST);
  assign act         = run & (idx >= ACT_FIRST) & (idx < TR_FIRST);
  assign trail_dmy   = run & (idx >= TR_FIRST);
endmodule

module ccd_seq_chk #(
  parameter int LEAD   = 64,
  parameter int ACTIVE = 5000,
  parameter int TRAIL  = 12,
  parameter int IW     = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rs,
  input logic [IW-1:0] pix_idx,
  input logic          lead_dmy,
  input logic          act,
  input logic          trail_dmy,
  input logic          frame_start,
  input logic          frame_end
);
  localparam logic [IW-1:0] LAST_IDX  = IW'(LEAD + ACTIVE + TRAIL - 1);
  localparam logic [IW-1:0] ACT_FIRST = IW'(LEAD);
  localparam logic [IW-1:0] TR_FIRST  = IW'(LEAD + ACTIVE);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (!rs || frame_start));
  // R3
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pix_idx == '0 && lead_dmy && rs));
  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_idx <= LAST_IDX);
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_idx != $past(pix_idx)) |-> (pix_idx == $past(pix_idx) + 1'b1 || frame_start));
  // R5
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_dmy, act, trail_dmy}));
  // R6
  act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (pix_idx >= ACT_FIRST && pix_idx < TR_FIRST));
  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!(lead_dmy || act || trail_dmy) || frame_start));
  // R8
  end_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (trail_dmy && pix_idx == LAST_IDX));
endmodule

bind ccd_seq ccd_seq_chk #(.LEAD(LEAD), .ACTIVE(ACTIVE), .TRAIL(TRAIL), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rs(rs), .pix_idx(pix_idx), .lead_dmy(lead_dmy),
  .act(act), .trail_dmy(trail_dmy), .frame_start(frame_start), .frame_end(frame_end)
);

// File: tb/test_ccd_seq.sv
module test_ccd_seq;
  localparam int CLK_PERIOD = 50;
  localparam int TOTAL      = 5076;
  localparam int FRAME_CLKS = TOTAL * 4;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0, rst_n = 1'b0, sg = 1'b0;
  logic ph1, ph2, rs, lead_dmy, act, trail_dmy, frame_start, frame_end;
  logic [12:0] pix_idx;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int t = 0, started = 0, sgp = 0;
  bit done = 0;

  ccd_seq i_ccd_seq (
    .clk(clk), .rst_n(rst_n), .sg(sg), .ph1(ph1), .ph2(ph2), .rs(rs),
    .pix_idx(pix_idx), .lead_dmy(lead_dmy), .act(act), .trail_dmy(trail_dmy),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      t = 0; started = 0; sgp = 0;
    end else begin
      if (sgp == 1 && sg == 1'b0) begin t = 0; started = 1; end
      else t++;
      sgp = int'(sg);
    end
  end

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, actual, expected, t);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit running;
      int e_idx, e_ph;
      running = (started == 1) && (t < FRAME_CLKS);
      e_idx = running ? t / 4 : (started == 1 ? TOTAL - 1 : 0);
      e_ph = (t / 4) % 2;
      chk(ph2 == e_ph[0] && ph1 == !e_ph[0], "R1 phases", int'({ph1, ph2}), e_ph == 1 ? 1 : 2);
      chk(rs == (running && t % 4 == 0), "R2 strobe", int'(rs), int'(running && t % 4 == 0));
      chk(frame_start == (running && t == 0), "R3 frame_start", int'(frame_start), int'(running && t == 0));
      chk(int'(pix_idx) == e_idx, "R4 pix_idx", int'(pix_idx), e_idx);
      chk(lead_dmy == (running && e_idx < 64), "R5 lead_dmy", int'(lead_dmy), int'(running && e_idx < 64));
      chk(act == (running && e_idx >= 64 && e_idx < 5064), "R6 act", int'(act),
          int'(running && e_idx >= 64 && e_idx < 5064));
      chk(trail_dmy == (running && e_idx >= 5064), "R7 trail_dmy", int'(trail_dmy), int'(running && e_idx >= 5064));
      chk(frame_end == (running && t == FRAME_CLKS - 1), "R8 frame_end", int'(frame_end),
          int'(running && t == FRAME_CLKS - 1));
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_clks(3);
    // R10: outputs held in reset
    chk(ph1 == 1'b1 && ph2 == 1'b0, "R10 phases in reset", int'({ph1, ph2}), 2);
    chk(pix_idx == '0 && !rs, "R10 idx/strobe in reset", int'(pix_idx), 0);
    chk({lead_dmy, act, trail_dmy, frame_start, frame_end} == 5'b0, "R10 flags in reset",
        int'({lead_dmy, act, trail_dmy, frame_start, frame_end}), 0);
    rst_n = 1'b1;
    wait_clks(20);
    sg = 1'b1; wait_clks(3);
    sg = 1'b0; wait_clks(FRAME_CLKS + 50);
    sg = 1'b1; wait_clks(10);
    sg = 1'b0; wait_clks(400);
    sg = 1'b1; wait_clks(2);
    sg = 1'b0; wait_clks(1);
    // R9: restart in mid-frame
    chk(pix_idx == '0 && frame_start, "R9 restart", int'(pix_idx), 0);
    wait_clks(FRAME_CLKS + 100);
    // R3: long high shift gate leaves idle state alone
    sg = 1'b1; wait_clks(3000);
    chk(pix_idx == 13'd5075 && !rs && !trail_dmy, "R3 sg high no effect", int'(pix_idx), 5075);
    sg = 1'b0; wait_clks(FRAME_CLKS + 20);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > WATCHDOG);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule